// File: doc/BRIEF.md
# Dual-Format Chroma Input Unpacker

This block sits at the front of a video datapath. It takes one pixel stream made of an 8-bit luma bus and an 8-bit chroma bus. The stream may use either of two sampling layouts. In the narrow layout, each pixel carries only two bits of each colour-difference component, so a full chroma pair is spread over four consecutive pixels. In the wide layout, the chroma bus alternates between a full U byte and a full V byte. Whichever layout arrives, the block always produces a 4:2:2 stream: luma on one bus, and U on even pixels and V on odd pixels on the other bus, all in two's-complement code.

Luma and chroma each have their own coding control, which tells the block whether that input is in offset binary or already in two's complement. In the narrow layout the block collects the slices of each four-pixel group, rebuilds the U and V bytes, and emits them as U, V, U, V beside the luma of that same group. A four-pixel group counter restarts at the start of every active line. Luma and the active flag travel through a delay line of matching length, so all outputs share one fixed latency.

Top module: `chroma_unpack`

## Requirements
- R1: While reset is asserted and after it is released, before any active pixel reaches the output, `lumaOut`, `chromaOut` and `outActive` are all 0.
- R2: `fmt422`=0 selects the 4:1:1 layout. In it, `chromaIn[7:6]` is a U slice, `chromaIn[5:4]` is the V slice of the same weight, and `chromaIn[3:0]` has no effect on any output.
- R3: In 4:1:1, the four pixels of a group (group phases 0..3) deliver the slices most significant first: bits 7:6, then 5:4, then 3:2, then 1:0, for U and V alike.
- R4: In 4:1:1, the output chroma for the four pixels of a complete group is U, V, U, V of that group's rebuilt pair, aligned with the luma of the same four pixels.
- R5: `fmt422`=1 selects the 4:2:2 layout. Each chroma byte is passed through per pixel, so U stays on even pixels and V on odd pixels.
- R6: `lumaTwos`=0 marks luma as offset binary, and the output is the input with bit 7 inverted. `lumaTwos`=1 passes luma unchanged.
- R7: `chromaTwos`=0 marks chroma as offset binary, and the rebuilt or passed value has bit 7 inverted. `chromaTwos`=1 leaves it unchanged. This setting is independent of `lumaTwos`.
- R8: Every pixel presented with `lineActive`=1 in clock cycle t appears on the outputs in cycle t+5, with `outActive`=1 in that cycle.
- R9: In any cycle with `outActive`=0, `lumaOut` and `chromaOut` are 0.
- R10: The group phase restarts at 0 on the first pixel after each rising edge of `lineActive`, even when the previous line ended partway through a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineActive | input | 1 | High for each active pixel of a line |
| lumaIn | input | 8 | Luma input sample |
| chromaIn | input | 8 | Chroma input (slices or full bytes) |
| fmt422 | input | 1 | 0: 4:1:1 layout, 1: 4:2:2 layout |
| lumaTwos | input | 1 | Luma input coding, 1 = two's complement |
| chromaTwos | input | 1 | Chroma input coding, 1 = two's complement |
| lumaOut | output | 8 | Luma output, two's complement |
| chromaOut | output | 8 | Chroma output, U on even / V on odd pixels |
| outActive | output | 1 | Marks output cycles that carry a pixel |

## Verification
Four properties are checked on every cycle. The group phase must advance by one, wrapping, across consecutive active pixels. The phase must restart after a rising edge of the line flag. The rebuilt chroma pair may change only after the last slice of a group. The outputs must be zero whenever no pixel is being emitted. The rebuilt values themselves can only be shown by the bench's scenarios. Those scenarios cover both layouts, all four coding combinations, the bit ordering of the slices, the fixed five-cycle alignment of luma and chroma, and a line that stops mid-group and is followed by a new line whose groups must start afresh.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  // Strobes handed from the control half to the datapath half
  typedef struct packed {
    logic act;        // pixel present this cycle
    logic lastSlice;  // final pixel of a narrow-layout group
    logic odd;        // odd group phase: selects V on the output
  } strobeT;

endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   lineActive,
  output strobeT strobe
);
  localparam int PH_W = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(GROUP - 1);

  logic            prevActive;
  logic [PH_W-1:0] phCnt;
  logic [PH_W-1:0] curPhase;
  logic            lineRise;

  assign lineRise = lineActive && !prevActive;
  assign curPhase = lineRise ? '0 : phCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      phCnt      <= '0;
    end else begin
      prevActive <= lineActive;
      if (lineActive) begin
        phCnt <= (curPhase == LAST_PH) ? '0 : curPhase + PH_W'(1);
      end
    end
  end

  always_comb begin
    strobe.act       = lineActive;
    strobe.lastSlice = lineActive && (curPhase == LAST_PH);
    strobe.odd       = curPhase[0];
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineActive && $past(lineActive) |->
      curPhase == (($past(curPhase) == LAST_PH) ? '0 : $past(curPhase) + PH_W'(1)));

  // R10
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineActive && !$past(lineActive) |=> phCnt == PH_W'(1 % GROUP));

endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] chromaIn,
  input  logic              fmt422,
  input  logic              lumaTwos,
  input  logic              chromaTwos,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] chromaOut,
  output logic              outActive
);
  localparam int GROUP = DATA_W / SLICE_W;
  localparam int ACC_W = DATA_W - SLICE_W;
  localparam int DEPTH = GROUP;

  function automatic logic [DATA_W-1:0] toTwos(input logic [DATA_W-1:0] v, input logic isTwos);
    return isTwos ? v : {~v[DATA_W-1], v[DATA_W-2:0]};
  endfunction

  // Slice reassembly for the narrow layout
  logic [SLICE_W-1:0] uSlice, vSlice;
  logic [ACC_W-1:0]   uAcc, vAcc;
  logic [DATA_W-1:0]  uHold, vHold;

  assign uSlice = chromaIn[DATA_W-1 -: SLICE_W];
  assign vSlice = chromaIn[DATA_W-1-SLICE_W -: SLICE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uAcc  <= '0;
      vAcc  <= '0;
      uHold <= '0;
      vHold <= '0;
    end else if (strobe.act) begin
      if (ACC_W > SLICE_W) begin
        uAcc <= {uAcc[ACC_W-SLICE_W-1:0], uSlice};
        vAcc <= {vAcc[ACC_W-SLICE_W-1:0], vSlice};
      end else begin
        uAcc <= ACC_W'(uSlice);
        vAcc <= ACC_W'(vSlice);
      end
      if (strobe.lastSlice) begin
        uHold <= toTwos({uAcc, uSlice}, chromaTwos);
        vHold <= toTwos({vAcc, vSlice}, chromaTwos);
      end
    end
  end

  // Alignment delay line: one group deep
  logic              stAct   [DEPTH];
  logic              stOdd   [DEPTH];
  logic [DATA_W-1:0] stLuma  [DEPTH];
  logic [DATA_W-1:0] stChroma[DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stAct[0]    <= 1'b0;
      stOdd[0]    <= 1'b0;
      stLuma[0]   <= '0;
      stChroma[0] <= '0;
    end else begin
      stAct[0]    <= strobe.act;
      stOdd[0]    <= strobe.odd;
      stLuma[0]   <= toTwos(lumaIn, lumaTwos);
      stChroma[0] <= toTwos(chromaIn, chromaTwos);
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stAct[g]    <= 1'b0;
        stOdd[g]    <= 1'b0;
        stLuma[g]   <= '0;
        stChroma[g] <= '0;
      end else begin
        stAct[g]    <= stAct[g-1];
        stOdd[g]    <= stOdd[g-1];
        stLuma[g]   <= stLuma[g-1];
        stChroma[g] <= stChroma[g-1];
      end
    end
  end

  logic [DATA_W-1:0] chromaSel;
  assign chromaSel = fmt422 ? stChroma[DEPTH-1] : (stOdd[DEPTH-1] ? vHold : uHold);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lumaOut   <= '0;
      chromaOut <= '0;
      outActive <= 1'b0;
    end else begin
      outActive <= stAct[DEPTH-1];
      lumaOut   <= stAct[DEPTH-1] ? stLuma[DEPTH-1] : '0;
      chromaOut <= stAct[DEPTH-1] ? chromaSel : '0;
    end
  end

  // R4
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.lastSlice) |-> $stable(uHold) && $stable(vHold));

  // R9
  blank_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stAct[DEPTH-1]) |-> !outActive && lumaOut == '0 && chromaOut == '0);

endmodule

// File: rtl/chroma_unpack.sv
module chroma_unpack
  import unpack_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineActive,
  input  logic [DATA_W-1:0] lumaIn,
  input  logic [DATA_W-1:0] chromaIn,
  input  logic              fmt422,
  input  logic              lumaTwos,
  input  logic              chromaTwos,
  output logic [DATA_W-1:0] lumaOut,
  output logic [DATA_W-1:0] chromaOut,
  output logic              outActive
);
  localparam int GROUP = DATA_W / SLICE_W;

  strobeT strobe;

  unpack_ctrl #(.GROUP(GROUP)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineActive(lineActive),
    .strobe    (strobe)
  );

  unpack_datapath #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lumaIn    (lumaIn),
    .chromaIn  (chromaIn),
    .fmt422    (fmt422),
    .lumaTwos  (lumaTwos),
    .chromaTwos(chromaTwos),
    .lumaOut   (lumaOut),
    .chromaOut (chromaOut),
    .outActive (outActive)
  );

endmodule

// File: tb/sim_chroma_unpack.sv
`timescale 1ns/1ps
module sim_chroma_unpack;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineActive = 1'b0;
  logic [7:0] lumaIn = '0, chromaIn = '0;
  logic       fmt422 = 1'b0, lumaTwos = 1'b0, chromaTwos = 1'b0;
  logic [7:0] lumaOut, chromaOut;
  logic       outActive;

  always #2.5 clk = ~clk;

  chroma_unpack u0 (
    .clk(clk), .rstN(rstN), .lineActive(lineActive),
    .lumaIn(lumaIn), .chromaIn(chromaIn),
    .fmt422(fmt422), .lumaTwos(lumaTwos), .chromaTwos(chromaTwos),
    .lumaOut(lumaOut), .chromaOut(chromaOut), .outActive(outActive)
  );

  typedef struct {
    logic [7:0] y;
    logic [7:0] c;
    bit         chk;
    int         due;
    string      tag;
  } expT;

  expT expQ[$];
  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] toTc(input logic [7:0] v, input bit tc);
    return tc ? v : (v ^ 8'h80);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outActive) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected pixel", 1, 0);
        end else begin
          expT e;
          e = expQ.pop_front();
          check(cyc == e.due, "R8 latency", cyc, e.due);
          check(lumaOut == e.y, "R6 luma", lumaOut, e.y);
          if (e.chk) check(chromaOut == e.c, e.tag, chromaOut, e.c);
        end
      end else begin
        check(lumaOut == 8'h00 && chromaOut == 8'h00, "R9 blank", {lumaOut, chromaOut}, 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lineActive = 1'b0;
      lumaIn   = 8'($urandom);
      chromaIn = 8'($urandom);
    end
  endtask

  // Drive one line; expected items go to the scoreboard queue
  task automatic driveLine(input int n, input bit f422, input bit lt, input bit ct, input string tagIn);
    logic [7:0] u, v;
    u = '0;
    v = '0;
    @(negedge clk);
    fmt422 = f422;
    lumaTwos = lt;
    chromaTwos = ct;
    for (int i = 0; i < n; i++) begin
      int p;
      expT e;
      p = i % 4;
      @(negedge clk);
      lineActive = 1'b1;
      lumaIn = 8'($urandom);
      e.y = toTc(lumaIn, lt);
      e.due = cyc + 5;
      e.tag = tagIn;
      if (f422) begin
        // R5: full byte each pixel
        chromaIn = 8'($urandom);
        e.c = toTc(chromaIn, ct);
        e.chk = 1'b1;
      end else begin
        // R2, R3: slices MSB first, low nibble is junk
        if (p == 0) begin
          u = 8'($urandom);
          v = 8'($urandom);
        end
        chromaIn = {u[7-2*p -: 2], v[7-2*p -: 2], 4'($urandom)};
        e.c = toTc((p % 2 == 0) ? u : v, ct);
        e.chk = ((i - p) + 4) <= n;
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    lineActive = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lumaOut == 0 && chromaOut == 0 && outActive == 0, "R1 in reset", {lumaOut, chromaOut}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(lumaOut == 0 && chromaOut == 0 && outActive == 0, "R1 after reset", {lumaOut, chromaOut}, 0);

    // R4 with R6/R7 offset-binary on both
    driveLine(16, 1'b0, 1'b0, 1'b0, "R4 R7 narrow");
    idle(8);
    // R4, luma two's complement, chroma offset
    driveLine(12, 1'b0, 1'b1, 1'b0, "R4 R7 narrow mixed");
    idle(8);
    // R7 chroma two's complement on narrow layout
    driveLine(8, 1'b0, 1'b0, 1'b1, "R3 R7 narrow tc");
    idle(8);
    // R5 wide layout, both codings
    driveLine(10, 1'b1, 1'b0, 1'b1, "R5 R7 wide");
    idle(8);
    driveLine(14, 1'b1, 1'b1, 1'b0, "R5 R7 wide mixed");
    idle(8);
    // R10: partial group, short gap, then a fresh line
    driveLine(6, 1'b0, 1'b1, 1'b1, "R4 partial");
    idle(2);
    driveLine(8, 1'b0, 1'b1, 1'b1, "R10 restart");
    idle(8);
    driveLine(7, 1'b1, 1'b0, 1'b0, "R5 wide odd");
    idle(2);
    driveLine(12, 1'b1, 1'b0, 1'b0, "R5 wide back to back");
    idle(10);

    check(expQ.size() == 0, "R8 drained", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule